// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetcher

This block reads the frame buffer on behalf of a display timing generator. It does not use a fixed base address and length. It follows a chain of descriptors held in memory. Software loads a descriptor address into the start register and raises `enable`. The fetcher reads the four-word descriptor at that address. It then moves the described number of 32-bit words from memory into the pixel FIFO, in bursts of `BURST` beats. When the frame data is done, it waits for the timing generator's end-of-frame pulse and then moves on to the descriptor that the first word points to.

A descriptor whose link word holds its own address makes one buffer repeat on every frame. Two descriptors that point at each other alternate between two buffers. The identifier word of the descriptor in use is shown on a status output. The memory port has one request outstanding at a time, and its responses come back in order.

Top module: `fb_desc_fetch`

## Requirements
- R1: While reset is held, and after it, no memory request and no FIFO write is made, and `cur_id` reads 0, until `enable` is seen high.
- R2: In idle with `enable` high, the fetcher requests a 4-beat read at the address last written through `start_we`/`start_addr`.
- R3: The descriptor words sit at byte offsets 0, 4, 8 and 12. Offset 0 is the link address, offset 4 the frame data byte address, offset 8 the identifier, and offset 12 the command. Bits 23:0 of the command give the frame length in 32-bit words.
- R4: Exactly the word count of frame words is written to the FIFO, in ascending address order, starting at the data address.
- R5: Data is requested in bursts of `BURST` beats, each at an address 4·`BURST` bytes above the one before. The last burst carries the remainder when the count is not a multiple of `BURST`. A request length is never 0 and never exceeds `BURST`.
- R6: No data burst is requested while `fifo_free` is below `BURST`.
- R7: A request held without `mem_req_ready` keeps its valid, address and length unchanged until it is accepted.
- R8: The next descriptor is read only on an `eof` pulse that arrives after the frame data is complete. An `eof` that arrives while data is still being fetched is ignored.
- R9: A descriptor that links to itself re-reads the same descriptor and streams the same data again after each `eof`.
- R10: `cur_id` changes only when a descriptor read completes, and then takes that descriptor's identifier.
- R11: If `enable` is low at the accepted `eof`, the fetcher goes idle and makes no further requests. A later enable restarts from the start register. A start write made while the fetcher is running only affects that later start.
- R12: A descriptor with a word count of 0 causes no data request. The fetcher waits for `eof` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request, sampled in idle and at end of frame |
| start_we | input | 1 | Start register write strobe |
| start_addr | input | 32 | Start descriptor byte address |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_len | output | $clog2(BURST+1) | Beats requested |
| mem_rsp_valid | input | 1 | Read beat valid |
| mem_rsp_data | input | 32 | Read beat data |
| fifo_wr | output | 1 | Pixel FIFO write strobe |
| fifo_data | output | 32 | Pixel FIFO write word |
| fifo_free | input | FREE_W | Free FIFO entries |
| eof | input | 1 | End-of-frame pulse from the timing generator |
| cur_id | output | 32 | Identifier of the descriptor in use |

## Verification
The bench builds the fetcher with `BURST` = 4 and gives it an 8-entry FIFO model. With these values, a sweep of word counts from 0 to 9 covers an empty frame, frames shorter than one burst, exact multiples of the burst, and every remainder. The small FIFO fills after two bursts, so the free-space hold and an early `eof` can be exercised within a single frame. Alternate runs add stalls on request acceptance and gaps between response beats. Self-linked and two-descriptor chains check that the descriptor is followed and that the identifier updates.

// File: rtl/fb_desc_fetch.sv
module fb_desc_fetch #(
  parameter int BURST  = 16,
  parameter int CW     = 24,
  parameter int FREE_W = 8,
  localparam int LW    = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start_we,
  input  logic [31:0]       start_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  output logic [LW-1:0]     mem_req_len,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              fifo_wr,
  output logic [31:0]       fifo_data,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              eof,
  output logic [31:0]       cur_id
);

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DRSP, S_DATA, S_BRSP, S_WAIT} st_t;

  st_t           st;
  logic [31:0]   start_r, desc_a, next_a, ptr, id_tmp;
  logic [CW-1:0] left;
  logic [LW-1:0] beat, cur_len, blen;
  logic          room;

  assign room          = fifo_free >= FREE_W'(BURST);
  assign blen          = (left >= CW'(BURST)) ? LW'(BURST) : LW'(left);
  assign mem_req_valid = (st == S_DREQ) || (st == S_DATA && room);
  assign mem_req_addr  = (st == S_DREQ) ? desc_a : ptr;
  assign mem_req_len   = (st == S_DREQ) ? LW'(4) : blen;
  assign fifo_wr       = (st == S_BRSP) && mem_rsp_valid;
  assign fifo_data     = mem_rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      start_r <= '0;
      desc_a  <= '0;
      next_a  <= '0;
      ptr     <= '0;
      id_tmp  <= '0;
      cur_id  <= '0;
      left    <= '0;
      beat    <= '0;
      cur_len <= '0;
    end else begin
      if (start_we) start_r <= start_addr;
      unique case (st)
        S_IDLE: if (enable) begin
          desc_a <= start_r;
          st     <= S_DREQ;
        end
        S_DREQ: if (mem_req_ready) begin
          beat <= '0;
          st   <= S_DRSP;
        end
        S_DRSP: if (mem_rsp_valid) begin
          beat <= beat + LW'(1);
          case (beat[1:0])
            2'd0: next_a <= mem_rsp_data;
            2'd1: ptr    <= mem_rsp_data;
            2'd2: id_tmp <= mem_rsp_data;
            default: begin
              left   <= mem_rsp_data[CW-1:0];
              cur_id <= id_tmp;
              st     <= (mem_rsp_data[CW-1:0] == '0) ? S_WAIT : S_DATA;
            end
          endcase
        end
        S_DATA: if (mem_req_valid && mem_req_ready) begin
          beat    <= '0;
          cur_len <= blen;
          st      <= S_BRSP;
        end
        S_BRSP: if (mem_rsp_valid) begin
          beat <= beat + LW'(1);
          ptr  <= ptr + 32'd4;
          left <= left - CW'(1);
          if (beat == cur_len - LW'(1))
            st <= (left == CW'(1)) ? S_WAIT : S_DATA;
        end
        S_WAIT: if (eof) begin
          if (enable) begin
            desc_a <= next_a;
            st     <= S_DREQ;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len));

  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_len != '0) && (mem_req_len <= LW'(BURST)));

  p_desc_after_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DREQ) && $past(st == S_WAIT) |-> $past(eof));

  p_id_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_id) |-> $past(st == S_DRSP && mem_rsp_valid));

  p_done_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (left == '0));

  p_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BRSP) && $past(st == S_DATA) |-> $past(fifo_free >= FREE_W'(BURST)));

endmodule

// File: tb/fb_desc_fetch_bench.sv
module fb_desc_fetch_bench;
  localparam int B = 4;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(B + 1);

  logic clk = 0, rst_n = 0, enable = 0, start_we = 0, eof = 0;
  logic [31:0] start_addr = 0;
  logic mem_req_valid, mem_req_ready, fifo_wr;
  logic [31:0] mem_req_addr, fifo_data, cur_id;
  logic [LW-1:0] mem_req_len;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic [7:0] fifo_free;

  int errors = 0, checks = 0;
  logic [31:0] mem [256];
  logic mbusy = 0, slow = 0, tog = 0, drain = 1;
  int maddr = 0, mleft = 0, fcnt = 0;
  int nreq = 0, nrx = 0;
  logic [31:0] rq_a [64];
  int rq_l [64];
  logic [31:0] rx [64];

  always #2.5 clk = ~clk;

  fb_desc_fetch #(.BURST(B), .CW(24), .FREE_W(8)) u_fb_desc_fetch (
    .clk, .rst_n, .enable, .start_we, .start_addr,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_req_len,
    .mem_rsp_valid, .mem_rsp_data, .fifo_wr, .fifo_data, .fifo_free,
    .eof, .cur_id);

  assign mem_req_ready = !mbusy && (!slow || tog);
  assign fifo_free = 8'(DEPTH - fcnt);

  always @(posedge clk) begin
    tog <= ~tog;
    mem_rsp_valid <= 0;
    if (mem_req_valid && mem_req_ready) begin
      mbusy <= 1; maddr <= int'(mem_req_addr[9:2]); mleft <= int'(mem_req_len);
    end else if (mbusy && (!slow || tog)) begin
      mem_rsp_valid <= 1; mem_rsp_data <= mem[maddr];
      maddr <= maddr + 1; mleft <= mleft - 1;
      if (mleft == 1) mbusy <= 0;
    end
    fcnt <= fcnt + (fifo_wr ? 1 : 0) - ((drain && fcnt > 0) ? 1 : 0);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_req_valid && mem_req_ready && nreq < 64) begin
      rq_a[nreq] = mem_req_addr; rq_l[nreq] = int'(mem_req_len);
      if (mem_req_addr >= 32'h100) check(fifo_free >= 8'(B), "R6 room at burst", fifo_free, B);
      nreq++;
    end
    if (fifo_wr && nrx < 64) begin rx[nrx] = fifo_data; nrx++; end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_eof; eof = 1; cyc(1); eof = 0; endtask
  task automatic clr; nreq = 0; nrx = 0; endtask
  task automatic wdesc(input int a, input int nx, input int d, input int id, input int n);
    mem[a/4] = nx; mem[a/4+1] = d; mem[a/4+2] = id; mem[a/4+3] = n;
  endtask
  task automatic set_start(input int a);
    start_addr = a; start_we = 1; cyc(1); start_we = 0;
  endtask

  task automatic verify(input int ri, input int desc, input int base, input int n, input int xi);
    check(rq_a[ri] == desc && rq_l[ri] == 4, "R2 desc read", rq_a[ri], desc);
    for (int b = 0; b * B < n; b++) begin
      int off = b * B;
      int ln = (n - off < B) ? n - off : B;
      check(rq_a[ri+1+b] == base + 4*off && rq_l[ri+1+b] == ln, "R5 burst",
            {rq_a[ri+1+b], 8'(rq_l[ri+1+b])}, {32'(base + 4*off), 8'(ln)});
    end
    for (int i = 0; i < n; i++)
      check(rx[xi+i] == (32'hD000_0000 | 32'(base/4 + i)), "R4 word", rx[xi+i],
            32'hD000_0000 | 32'(base/4 + i));
  endtask

  task automatic stop_run;
    enable = 0; pulse_eof(); cyc(10);
  endtask

  bit done = 0;
  initial begin
    #(5ns * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 | 32'(i);
    cyc(3);
    check(!mem_req_valid && !fifo_wr && cur_id == 0, "R1 in reset", {mem_req_valid, fifo_wr}, 0);
    rst_n = 1; cyc(5);
    check(nreq == 0 && nrx == 0 && cur_id == 0, "R1 after reset", nreq, 0);

    // R3 R4 R5 R10 R12: sweep word counts 0..9
    for (int n = 0; n <= 9; n++) begin
      slow = n[0];
      wdesc(0, 0, 32'h100, 32'h100 + n, n);
      set_start(0); clr(); enable = 1; cyc(150);
      check(nreq == 1 + (n + B - 1) / B, "R8 R12 request count", nreq, 1 + (n + B - 1) / B);
      check(nrx == n, "R4 count", nrx, n);
      verify(0, 0, 32'h100, n, 0);
      check(cur_id == 32'h100 + n, "R10 R3 id", cur_id, 32'h100 + n);
      stop_run(); clr(); cyc(30);
      check(nreq == 0 && nrx == 0, "R11 idle after eof", nreq, 0);
    end

    // R6 R8: FIFO full mid-frame, early eof ignored; then R9 self link
    slow = 0; drain = 0;
    wdesc(0, 0, 32'h100, 32'h77, 9);
    clr(); enable = 1; cyc(100);
    check(nreq == 3 && nrx == 8, "R6 held on full FIFO", nreq, 3);
    pulse_eof(); cyc(50);
    check(nreq == 3, "R8 early eof ignored", nreq, 3);
    drain = 1; cyc(100);
    check(nreq == 4 && nrx == 9, "R8 no desc before eof", nreq, 4);
    verify(0, 0, 32'h100, 9, 0);
    pulse_eof(); cyc(150);
    check(nreq == 8 && nrx == 18, "R9 repeat count", nreq, 8);
    verify(4, 0, 32'h100, 9, 9);
    stop_run();

    // R10 R11: two-descriptor chain, start write while running
    wdesc(0, 32'h40, 32'h100, 32'h55, 3);
    wdesc(32'h40, 0, 32'h200, 32'h66, 5);
    slow = 1; set_start(0); clr(); enable = 1; cyc(100);
    check(cur_id == 32'h55, "R10 id first", cur_id, 32'h55);
    set_start(32'h40);
    pulse_eof(); cyc(150);
    check(cur_id == 32'h66, "R10 id second", cur_id, 32'h66);
    check(nreq == 5 && rq_a[2] == 32'h40, "R11 chain followed, start ignored", rq_a[2], 32'h40);
    verify(0, 0, 32'h100, 3, 0);
    verify(2, 32'h40, 32'h200, 5, 3);
    stop_run(); clr(); enable = 1; cyc(150);
    check(nreq >= 1 && rq_a[0] == 32'h40, "R11 restart from new start", rq_a[0], 32'h40);
    check(cur_id == 32'h66, "R10 id on restart", cur_id, 32'h66);
    stop_run();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule